// File: doc/BRIEF.md
# Integer ALU with Operation Decode

This block is the combinational arithmetic-logic unit of a 32-bit RISC-V base integer core, with the small operation decoder folded in. The datapath gives it two operands. It also gives it a flag that says whether the second operand is a register value or an already extended immediate, the 3-bit funct3 field, and one discriminator bit: funct7 bit 5 in register form, instruction bit 30 in immediate form. The block returns the result and a flag that is high when the result is zero.

The funct3 codes are fixed and do not depend on the operand form:

| funct3 | Operation |
|--------|-----------|
| 000 | add or subtract |
| 001 | shift left |
| 010 | signed set-less-than |
| 011 | unsigned set-less-than |
| 100 | xor |
| 101 | shift right |
| 110 | or |
| 111 | and |

The discriminator bit picks subtraction only in register form. In both forms it picks the arithmetic variant of the right shift. There is no clock and no state: the outputs follow the inputs in the same cycle.

Top module: `rv_int_alu`

## Requirements
- R1: With funct3 000 and either register form with the discriminator at 0, or immediate form with any discriminator value, the result is op_a + op_b modulo 2^32.
- R2: With funct3 000, register form and the discriminator at 1, the result is op_a - op_b modulo 2^32.
- R3: With funct3 001, the result is op_a shifted left by op_b[4:0], filled with zeros. Bits 31:5 of op_b have no effect.
- R4: With funct3 010, the result is 1 when op_a < op_b as two's-complement numbers, and 0 otherwise.
- R5: With funct3 011, the result is 1 when op_a < op_b as unsigned numbers, and 0 otherwise.
- R6: With funct3 100, the result is op_a ^ op_b. An all-ones op_b yields the bitwise inverse of op_a.
- R7: With funct3 101 and the discriminator at 0, the result is op_a shifted right by op_b[4:0], filled with zeros. This holds in both operand forms.
- R8: With funct3 101 and the discriminator at 1, the result is op_a shifted right by op_b[4:0], filled with copies of op_a[31]. This holds in both operand forms.
- R9: With funct3 110 the result is op_a | op_b. With funct3 111 it is op_a & op_b.
- R10: zero is 1 exactly when all 32 bits of the result are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (rs1 value) |
| op_b | input | 32 | Second operand: register value or extended immediate |
| imm_form | input | 1 | 1 when op_b is an immediate |
| funct3 | input | 3 | Operation class field |
| alt_bit | input | 1 | funct7 bit 5, or instruction bit 30 in immediate form |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench builds the unit with its default width parameter: XLEN of 32 and a derived shift-amount width of 5. This puts every shift distance from 0 to 31 in reach, including a distance field of 0 whose upper operand bits are set. It also covers the sign-boundary operands 0x80000000 and 0x7FFFFFFF, where signed and unsigned comparisons disagree. Random operands are mixed with these corner values and run through all funct3, form and discriminator combinations. Each result is compared against a bench model built directly from the requirements.

// File: rtl/rv_int_alu.sv
module rv_int_alu #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            imm_form,
  input  logic [2:0]      funct3,
  input  logic            alt_bit,
  output logic [XLEN-1:0] result,
  output logic            zero
);
  localparam int SHW = $clog2(XLEN);

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_SLL, K_SLT, K_SLTU, K_XOR, K_SRL, K_SRA, K_OR, K_AND
  } kind_e;

  kind_e kind;

  always_comb begin
    unique case (funct3)
      3'b000:  kind = (alt_bit && !imm_form) ? K_SUB : K_ADD;
      3'b001:  kind = K_SLL;
      3'b010:  kind = K_SLT;
      3'b011:  kind = K_SLTU;
      3'b100:  kind = K_XOR;
      3'b101:  kind = alt_bit ? K_SRA : K_SRL;
      3'b110:  kind = K_OR;
      default: kind = K_AND;
    endcase
  end

  logic            use_sub;
  logic [XLEN-1:0] b_eff;
  logic [XLEN:0]   sum_ext;
  logic            lt_u, lt_s;
  logic [SHW-1:0]  shamt;
  logic            fill;
  logic [XLEN:0]   sr_ext;
  logic [XLEN-1:0] sr_res, sl_res;

  assign use_sub = (kind != K_ADD);
  assign b_eff   = use_sub ? ~op_b : op_b;
  assign sum_ext = {1'b0, op_a} + {1'b0, b_eff} + {{XLEN{1'b0}}, use_sub};
  assign lt_u    = ~sum_ext[XLEN];
  assign lt_s    = (op_a[XLEN-1] ^ op_b[XLEN-1]) ? op_a[XLEN-1] : sum_ext[XLEN-1];

  assign shamt   = op_b[SHW-1:0];
  assign fill    = (kind == K_SRA) & op_a[XLEN-1];
  assign sr_ext  = $signed({fill, op_a}) >>> shamt;
  assign sr_res  = sr_ext[XLEN-1:0];
  assign sl_res  = op_a << shamt;

  always_comb begin
    unique case (kind)
      K_ADD, K_SUB: result = sum_ext[XLEN-1:0];
      K_SLL:        result = sl_res;
      K_SLT:        result = {{(XLEN-1){1'b0}}, lt_s};
      K_SLTU:       result = {{(XLEN-1){1'b0}}, lt_u};
      K_XOR:        result = op_a ^ op_b;
      K_SRL, K_SRA: result = sr_res;
      K_OR:         result = op_a | op_b;
      default:      result = op_a & op_b;
    endcase
  end

  assign zero = ~|result;
endmodule

// File: rtl/rv_int_alu_chk.sv
module rv_int_alu_chk #(
  parameter int XLEN = 32
) (
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b,
  input logic            imm_form,
  input logic [2:0]      funct3,
  input logic            alt_bit,
  input logic [XLEN-1:0] result,
  input logic            zero
);
  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0] low_mask;
  assign low_mask = ~({XLEN{1'b1}} << op_b[SHW-1:0]);

  always_comb begin
    if (funct3 == 3'b010 || funct3 == 3'b011)
      p_slt_bool_r4: assert (result[XLEN-1:1] == '0);
    if (funct3 == 3'b100 && op_b == {XLEN{1'b1}})
      p_xor_inverts_r6: assert (result == ~op_a);
    if (funct3 == 3'b000 && !imm_form && alt_bit)
      p_sub_equal_r2: assert (zero == (op_a == op_b));
    if (funct3 == 3'b001)
      p_sll_low_clear_r3: assert ((result & low_mask) == '0);
    if (funct3 == 3'b101 && alt_bit)
      p_sra_sign_kept_r8: assert (result[XLEN-1] == op_a[XLEN-1]);
    if (funct3 == 3'b101 && !alt_bit && op_b[SHW-1:0] != '0)
      p_srl_top_clear_r7: assert (!result[XLEN-1]);
    if (funct3 == 3'b111 && (op_a & op_b) == '0)
      p_and_zero_flag_r10: assert (zero);
  end
endmodule

bind rv_int_alu rv_int_alu_chk #(.XLEN(XLEN)) u_chk (
  .op_a(op_a), .op_b(op_b), .imm_form(imm_form), .funct3(funct3),
  .alt_bit(alt_bit), .result(result), .zero(zero)
);

// File: tb/rv_int_alu_tb.sv
module rv_int_alu_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [31:0] op_a, op_b, result;
  logic        imm_form, alt_bit, zero;
  logic [2:0]  funct3;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  rv_int_alu u_dut (
    .op_a(op_a), .op_b(op_b), .imm_form(imm_form), .funct3(funct3),
    .alt_bit(alt_bit), .result(result), .zero(zero)
  );

  // {imm_form, alt_bit, funct3, a, b, expected}
  localparam int NV = 17;
  localparam logic [100:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'b000, 32'h00000005, 32'h00000007, 32'h0000000C},
    {1'b1, 1'b1, 3'b000, 32'h00000010, 32'h00000400, 32'h00000410},
    {1'b0, 1'b1, 3'b000, 32'h00000003, 32'h00000005, 32'hFFFFFFFE},
    {1'b0, 1'b0, 3'b000, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},
    {1'b0, 1'b0, 3'b001, 32'h00000001, 32'h0000003F, 32'h80000000},
    {1'b0, 1'b0, 3'b010, 32'hFFFFFFFF, 32'h00000001, 32'h00000001},
    {1'b0, 1'b0, 3'b011, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},
    {1'b1, 1'b0, 3'b010, 32'h80000000, 32'h7FFFFFFF, 32'h00000001},
    {1'b1, 1'b0, 3'b011, 32'h00000001, 32'h00000002, 32'h00000001},
    {1'b1, 1'b0, 3'b100, 32'h12345678, 32'hFFFFFFFF, 32'hEDCBA987},
    {1'b0, 1'b0, 3'b101, 32'h80000000, 32'h00000004, 32'h08000000},
    {1'b0, 1'b1, 3'b101, 32'h80000000, 32'h00000004, 32'hF8000000},
    {1'b1, 1'b1, 3'b101, 32'h80000000, 32'h0000041F, 32'hFFFFFFFF},
    {1'b1, 1'b0, 3'b110, 32'hF0F00000, 32'h00000F0F, 32'hF0F00F0F},
    {1'b0, 1'b0, 3'b111, 32'hFF00FF00, 32'h0FF00FF0, 32'h0F000F00},
    {1'b0, 1'b1, 3'b000, 32'hDEADBEEF, 32'hDEADBEEF, 32'h00000000},
    {1'b1, 1'b0, 3'b101, 32'h80000001, 32'h00000020, 32'h80000001}
  };

  function automatic string req_of(logic f_imm, logic f_alt, logic [2:0] f3);
    case (f3)
      3'b000:  return (f_alt && !f_imm) ? "R2" : "R1";
      3'b001:  return "R3";
      3'b010:  return "R4";
      3'b011:  return "R5";
      3'b100:  return "R6";
      3'b101:  return f_alt ? "R8" : "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] model(logic f_imm, logic f_alt, logic [2:0] f3,
                                        logic [31:0] a, logic [31:0] b);
    int sh = int'(b[4:0]);
    case (f3)
      3'b000:  return (f_alt && !f_imm) ? a - b : a + b;
      3'b001:  return a << sh;
      3'b010:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3'b011:  return (a < b) ? 32'd1 : 32'd0;
      3'b100:  return a ^ b;
      3'b101:  return f_alt ? 32'($signed(a) >>> sh) : a >> sh;
      3'b110:  return a | b;
      default: return a & b;
    endcase
  endfunction

  task automatic apply_check(logic f_imm, logic f_alt, logic [2:0] f3,
                             logic [31:0] a, logic [31:0] b, logic [31:0] exp);
    @(negedge clk);
    imm_form = f_imm; alt_bit = f_alt; funct3 = f3; op_a = a; op_b = b;
    #2;
    total++;
    if (result !== exp) begin
      bad++;
      $display("FAIL %s f3=%b imm=%b alt=%b a=%h b=%h result=%h expected=%h",
               req_of(f_imm, f_alt, f3), f3, f_imm, f_alt, a, b, result, exp);
    end
    total++;
    if (zero !== (exp == 32'd0)) begin
      bad++;
      $display("FAIL R10 a=%h b=%h f3=%b zero=%b expected=%b",
               a, b, f3, zero, exp == 32'd0);
    end
  endtask

  function automatic logic [31:0] pick_operand();
    case ($urandom_range(0, 7))
      0: return 32'h00000000;
      1: return 32'hFFFFFFFF;
      2: return 32'h80000000;
      3: return 32'h7FFFFFFF;
      4: return 32'h00000001;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    imm_form = 0; alt_bit = 0; funct3 = 0; op_a = 0; op_b = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Idle inputs: add of zeros, R1 and R10
    apply_check(1'b0, 1'b0, 3'b000, 32'd0, 32'd0, 32'd0);

    for (int i = 0; i < NV; i++)
      apply_check(VEC[i][100], VEC[i][99], VEC[i][98:96],
                  VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);

    // R3: upper bits of op_b ignored for shift left
    apply_check(1'b0, 1'b0, 3'b001, 32'h0000000F, 32'hFFFFFFE4, 32'h000000F0);
    // R6: all-ones xor across several operands
    apply_check(1'b0, 1'b0, 3'b100, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF);
    apply_check(1'b0, 1'b0, 3'b100, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000);
    // R8: arithmetic shift of a positive value fills with zeros
    apply_check(1'b0, 1'b1, 3'b101, 32'h40000000, 32'h0000001E, 32'h00000001);
    // R2: subtraction wrap
    apply_check(1'b0, 1'b1, 3'b000, 32'h00000000, 32'h00000001, 32'hFFFFFFFF);
    // R4/R5: equal operands give 0
    apply_check(1'b0, 1'b0, 3'b010, 32'h80000000, 32'h80000000, 32'h00000000);
    apply_check(1'b0, 1'b0, 3'b011, 32'h80000000, 32'h80000000, 32'h00000000);

    for (int i = 0; i < 3000; i++) begin
      logic        r_imm = 1'($urandom());
      logic        r_alt = 1'($urandom());
      logic [2:0]  r_f3  = 3'($urandom());
      logic [31:0] r_a   = pick_operand();
      logic [31:0] r_b   = pick_operand();
      apply_check(r_imm, r_alt, r_f3, r_a, r_b, model(r_imm, r_alt, r_f3, r_a, r_b));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule